// File: doc/BRIEF.md
# Multi-Channel Numerically Controlled Oscillator

This block contains a bank of independent phase-accumulator oscillators, three by default. Each channel keeps a 20-bit phase accumulator and adds its own 20-bit tuning word to it once per update tick. The accumulator wraps around at 2^20. A prescaler counter is shared by all channels. Each channel picks one of eight tick rates from it, so the output frequency is tuning_word / 2^20 times the tick rate.

Each channel has one of two output modes. In square mode the output is the accumulator's most significant bit, which gives a 50% duty waveform. In pulse mode the output goes high when the accumulator wraps and stays high for a programmable number of ticks. A single global enable starts the bank. Clearing it returns every accumulator, every pulse and the prescaler to zero. All settings are written through a simple synchronous write port.

Top module: `nco_bank`

## Requirements
- R1: Each channel holds its own 20-bit accumulator. On every one of its ticks the accumulator becomes (accumulator + tuning word) mod 2^20. Between ticks it does not change. Channels do not affect one another.
- R2: In square mode (config bit 3 = 0) the channel output equals bit 19 of its accumulator.
- R3: In pulse mode (config bit 3 = 1) the output rises on the tick on which the accumulator wraps past 2^20. It then stays high for exactly 2^E ticks, where E is config bits [6:4] (1 to 128 ticks). A wrap during a pulse restarts the full length.
- R4: Config bits [2:0] select the tick divisor. The codes 0 through 7 give 2, 4, 8, 64, 128, 1024, 2048 and 4096 clock cycles. After the enable write, the first tick updates the accumulator N cycles later, where N is the divisor.
- R5: With a tuning word of zero, a channel's output stays constant at 0 in both modes.
- R6: Writing 0 to the enable bit clears all accumulators, pulses and outputs to 0 at that clock edge. After re-enabling, every channel restarts from an accumulator of zero.
- R7: A new tuning word written while running is used from the channel's next tick on. The accumulator is not reset.
- R8: The write port uses the following addresses. Address c (0..2) holds channel c's tuning word. Address 3 bit 0 is the global enable. Address 4+c holds channel c's config. A write to address 7 changes nothing.
- R9: After reset the enable is 0 and all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the register port |
| wr_addr | input | 3 | Register address |
| wr_data | input | 20 | Write data |
| nco_out | output | 3 | One output per channel |

## Verification
The assertions take for granted that the inputs carry known values after reset. They also assume that a register write completes within one clock cycle and has no other hold condition. They accept a divisor change at any time, because they check the ordering of the tick strobes rather than absolute tick times. The bench keeps within these limits by driving every write on the falling edge. It changes divisors and modes only while the bank is disabled. The only live writes are a tuning word and a write to the unused address. Each of these lands between two ticks, so the bench's tick count stays exact.

// File: rtl/nco_bank_pkg.sv
package nco_bank_pkg;

   localparam int unsigned SEL_W   = 3;
   localparam int unsigned EXP_W   = 3;
   localparam int unsigned NUM_SEL = 2 ** SEL_W;

   typedef enum logic {
      OUT_SQUARE = 1'b0,
      OUT_PULSE  = 1'b1
   } out_mode_e;

   // per-channel configuration word, bit 0 is div_sel[0]
   typedef struct packed {
      logic [EXP_W-1:0] pexp;
      out_mode_e        mode;
      logic [SEL_W-1:0] div_sel;
   } ch_cfg_t;

   // log2 of the tick divisor for each select code
   function automatic int unsigned div_log2(input int unsigned sel);
      case (sel)
         0:       return 1;
         1:       return 2;
         2:       return 3;
         3:       return 6;
         4:       return 7;
         5:       return 10;
         6:       return 11;
         default: return 12;
      endcase
   endfunction

   function automatic int unsigned max_div_log2(input int unsigned nsel);
      int unsigned m;
      m = 1;
      for (int unsigned i = 0; i < nsel; i++) begin
         if (div_log2(i) > m) m = div_log2(i);
      end
      return m;
   endfunction

endpackage

// File: rtl/nco_prescaler.sv
module nco_prescaler
   import nco_bank_pkg::*;
#(
   parameter int unsigned N_SEL = NUM_SEL
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   output logic [N_SEL-1:0] tick
);

   localparam int unsigned CNT_W = max_div_log2(N_SEL);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!en) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   generate
      for (genvar i = 0; i < N_SEL; i++) begin : g_tap
         localparam int unsigned L = div_log2(i);
         assign tick[i] = en & (&cnt_q[L-1:0]);

         if (i > 0) begin : g_nest
            // R4: a slower tick always coincides with every faster one
            a_r4_nested_ticks: assert property (@(posedge clk) disable iff (!rst_n)
               tick[i] |-> tick[i-1]);
         end
      end
   endgenerate

   // R6: a disabled bank restarts its divider from zero
   a_r6_presc_clear: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (cnt_q == '0));

endmodule

// File: rtl/nco_regs.sv
module nco_regs
   import nco_bank_pkg::*;
#(
   parameter int unsigned NUM_CH = 3,
   parameter int unsigned ACC_W  = 20,
   parameter int unsigned ADDR_W = 3
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         wr_en,
   input  logic [ADDR_W-1:0]            wr_addr,
   input  logic [ACC_W-1:0]             wr_data,
   output logic                         en,
   output logic [NUM_CH-1:0][ACC_W-1:0] tw,
   output ch_cfg_t [NUM_CH-1:0]         cfg
);

   localparam int unsigned CTRL_ADDR = NUM_CH;
   localparam int unsigned CFG_BASE  = NUM_CH + 1;
   localparam int unsigned CFG_W     = $bits(ch_cfg_t);

   logic ctrl_hit;
   assign ctrl_hit = wr_en && (wr_addr == ADDR_W'(CTRL_ADDR));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en <= 1'b0;
      end else if (ctrl_hit) begin
         en <= wr_data[0];
      end
   end

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         logic [ACC_W-1:0] tw_q;
         ch_cfg_t          cfg_q;
         logic             tw_hit;
         logic             cfg_hit;

         assign tw_hit  = wr_en && (wr_addr == ADDR_W'(c));
         assign cfg_hit = wr_en && (wr_addr == ADDR_W'(CFG_BASE + c));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               tw_q <= '0;
            end else if (tw_hit) begin
               tw_q <= wr_data;
            end
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cfg_q <= '0;
            end else if (cfg_hit) begin
               cfg_q <= ch_cfg_t'(wr_data[CFG_W-1:0]);
            end
         end

         assign tw[c]  = tw_q;
         assign cfg[c] = cfg_q;

         // R8: a tuning word only changes through its own address
         a_r8_tw_decode: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && (wr_addr == ADDR_W'(c))) |=> $stable(tw[c]));
      end
   endgenerate

   // R8: the enable only changes through the control address
   a_r8_ctrl_decode: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && (wr_addr == ADDR_W'(CTRL_ADDR))) |=> $stable(en));

endmodule

// File: rtl/nco_channel.sv
module nco_channel
   import nco_bank_pkg::*;
#(
   parameter int unsigned ACC_W    = 20,
   parameter int unsigned N_SEL    = NUM_SEL,
   parameter bit          PULSE_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [N_SEL-1:0] tick_vec,
   input  logic [ACC_W-1:0] tw,
   input  ch_cfg_t          cfg,
   output logic             out
);

   localparam int unsigned PCNT_W = 2 ** EXP_W;

   logic [ACC_W-1:0] acc_q;
   logic [ACC_W:0]   sum;
   logic             tick;
   logic             wrap;
   logic             pulse_lvl;

   assign tick = tick_vec[cfg.div_sel];
   assign sum  = {1'b0, acc_q} + {1'b0, tw};
   assign wrap = en && tick && sum[ACC_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
      end else if (!en) begin
         acc_q <= '0;
      end else if (tick) begin
         acc_q <= sum[ACC_W-1:0];
      end
   end

   generate
      if (PULSE_EN) begin : g_pulse
         logic [PCNT_W-1:0] pcnt_q;
         logic [PCNT_W-1:0] plen;

         assign plen = PCNT_W'(1) << cfg.pexp;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pcnt_q <= '0;
            end else if (!en) begin
               pcnt_q <= '0;
            end else if (tick) begin
               if (wrap) begin
                  pcnt_q <= plen;
               end else if (pcnt_q != '0) begin
                  pcnt_q <= pcnt_q - 1'b1;
               end
            end
         end

         assign pulse_lvl = (pcnt_q != '0);

         // R3: the remaining pulse length never exceeds the longest setting
         a_r3_pulse_bound: assert property (@(posedge clk) disable iff (!rst_n)
            pcnt_q <= PCNT_W'(2 ** (PCNT_W - 1)));
         // R3: a wrap in pulse mode raises the output on the next cycle
         a_r3_pulse_start: assert property (@(posedge clk) disable iff (!rst_n)
            (wrap && cfg.mode == OUT_PULSE && en) |=>
               (out || !en || cfg.mode != OUT_PULSE));
      end else begin : g_no_pulse
         assign pulse_lvl = 1'b0;
      end
   endgenerate

   always_comb begin
      unique case (cfg.mode)
         OUT_PULSE: out = en & pulse_lvl;
         default:   out = en & acc_q[ACC_W-1];
      endcase
   end

   // R1: one tick adds exactly the tuning word, modulo the accumulator range
   a_r1_step: assert property (@(posedge clk) disable iff (!rst_n)
      (en && tick) |=> (acc_q == ACC_W'($past(acc_q) + $past(tw)) || !en));
   // R1: no tick, no change
   a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !tick) |=> ($stable(acc_q) || !en));
   // R5: a zero tuning word never moves the phase
   a_r5_zero_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (tw == '0) |=> ($stable(acc_q) || $fell(en)));
   // R6: a cleared enable empties the accumulator
   a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (acc_q == '0));

endmodule

// File: rtl/nco_bank.sv
module nco_bank
   import nco_bank_pkg::*;
#(
   parameter int unsigned NUM_CH   = 3,
   parameter int unsigned ACC_W    = 20,
   parameter bit          PULSE_EN = 1'b1,
   parameter int unsigned ADDR_W   = $clog2(2 * NUM_CH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [ACC_W-1:0]  wr_data,
   output logic [NUM_CH-1:0] nco_out
);

   localparam int unsigned MIN_ADDR_W = $clog2(2 * NUM_CH + 1);
   localparam int unsigned CFG_W      = $bits(ch_cfg_t);

   generate
      if (NUM_CH < 1 || ACC_W < CFG_W || ACC_W < 2 || ADDR_W < MIN_ADDR_W) begin : g_bad_cfg
         $error("nco_bank: parameter set out of range");
      end
   endgenerate

   logic                         en;
   logic [NUM_CH-1:0][ACC_W-1:0] tw;
   ch_cfg_t [NUM_CH-1:0]         cfg;
   logic [NUM_SEL-1:0]           tick_vec;

   nco_regs #(
      .NUM_CH (NUM_CH),
      .ACC_W  (ACC_W),
      .ADDR_W (ADDR_W)
   ) i_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .en      (en),
      .tw      (tw),
      .cfg     (cfg)
   );

   nco_prescaler #(
      .N_SEL (NUM_SEL)
   ) i_presc (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (en),
      .tick  (tick_vec)
   );

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         nco_channel #(
            .ACC_W    (ACC_W),
            .N_SEL    (NUM_SEL),
            .PULSE_EN (PULSE_EN)
         ) i_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .en       (en),
            .tick_vec (tick_vec),
            .tw       (tw[c]),
            .cfg      (cfg[c]),
            .out      (nco_out[c])
         );
      end
   endgenerate

   // R9 / R6: outputs are quiet whenever the bank was just disabled
   a_r6_outputs_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(en) |-> (nco_out == '0));

endmodule

// File: tb/test_nco_bank.sv
module test_nco_bank;

   localparam int CLK_PERIOD = 10;
   localparam int NCH        = 3;

   logic        clk;
   logic        rst_n;
   logic        wr_en;
   logic [2:0]  wr_addr;
   logic [19:0] wr_data;
   logic [2:0]  nco_out;

   int n_checks;
   int n_fail;
   int cyc;
   longint tw_b [NCH];
   int     sel_b [NCH];
   int     mode_b [NCH];
   int     pexp_b [NCH];

   nco_bank i_nco_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .nco_out (nco_out)
   );

   initial clk = 1'b0;
   always #(CLK_PERIOD / 2) clk = ~clk;

   // R4 divisor table
   function automatic longint div_of(input int sel);
      case (sel)
         0: return 2;
         1: return 4;
         2: return 8;
         3: return 64;
         4: return 128;
         5: return 1024;
         6: return 2048;
         default: return 4096;
      endcase
   endfunction

   // expected output c cycles after the enable edge (R1..R4)
   function automatic bit exp_out(input int ch, input int c);
      longint k;
      longint len;
      k = longint'(c) / div_of(sel_b[ch]);
      if (mode_b[ch] == 0) begin
         return bit'(((k * tw_b[ch]) % 1048576) >> 19);
      end
      len = longint'(1) << pexp_b[ch];
      for (longint j = k - len + 1; j <= k; j++) begin
         if (j >= 1 && ((j * tw_b[ch]) / 1048576) != (((j - 1) * tw_b[ch]) / 1048576))
            return 1'b1;
      end
      return 1'b0;
   endfunction

   task automatic check(input bit got, input bit exp, input string req, input string what);
      n_checks++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: %s got=%0b expected=%0b", req, what, got, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr(input int addr, input longint data);
      wr_en   = 1'b1;
      wr_addr = 3'(addr);
      wr_data = 20'(data);
      @(posedge clk);
      @(negedge clk);
      wr_en   = 1'b0;
   endtask

   task automatic setup(input int ch, input longint tw, input int sel, input int mode, input int pexp);
      tw_b[ch]   = tw;
      sel_b[ch]  = sel;
      mode_b[ch] = mode;
      pexp_b[ch] = pexp;
      wr(ch, tw);
      wr(4 + ch, longint'((pexp << 4) | (mode << 3) | sel));
   endtask

   task automatic enable_bank();
      wr(3, 1);
      cyc = 0;
   endtask

   task automatic run(input int n, input string req);
      for (int i = 0; i < n; i++) begin
         step(1);
         cyc++;
         for (int ch = 0; ch < NCH; ch++)
            check(nco_out[ch], exp_out(ch, cyc), req, $sformatf("ch%0d cycle %0d", ch, cyc));
      end
   endtask

   // R9: reset state
   task automatic t_reset();
      for (int ch = 0; ch < NCH; ch++) check(nco_out[ch], 1'b0, "R9", "output after reset");
      step(5);
      for (int ch = 0; ch < NCH; ch++) check(nco_out[ch], 1'b0, "R9", "output idle before enable");
   endtask

   // R1 R2 R4: three square channels at different rates
   task automatic t_square();
      wr(3, 0);
      setup(0, 'h40000, 0, 0, 0);
      setup(1, 'h30000, 1, 0, 0);
      setup(2, 'h80000, 2, 0, 0);
      enable_bank();
      run(96, "R2");
   endtask

   // R3: pulse lengths 2, 128 (retriggered) and 1
   task automatic t_pulse();
      wr(3, 0);
      setup(0, 'h40000, 1, 1, 1);
      setup(1, 'h02000, 0, 1, 7);
      setup(2, 'h80000, 3, 1, 0);
      enable_bank();
      run(640, "R3");
   endtask

   // R4: slowest divisors
   task automatic t_slow_div();
      wr(3, 0);
      setup(0, 'h80000, 7, 0, 0);
      setup(1, 'h80000, 6, 0, 0);
      setup(2, 'h80000, 5, 1, 2);
      enable_bank();
      run(8200, "R4");
   endtask

   // R5: zero tuning word holds the output
   task automatic t_zero();
      wr(3, 0);
      setup(0, 0, 4, 0, 0);
      setup(1, 0, 0, 1, 0);
      setup(2, 'h80000, 4, 0, 0);
      enable_bank();
      run(600, "R5");
   endtask

   // R6: disable clears everything, re-enable starts from zero
   task automatic t_disable();
      wr(3, 0);
      setup(0, 'h60000, 0, 0, 0);
      setup(1, 'h40000, 0, 1, 3);
      setup(2, 'h80000, 0, 0, 0);
      enable_bank();
      run(3, "R6");
      check(nco_out[2], 1'b1, "R6", "ch2 high before disable");
      wr(3, 0);
      for (int ch = 0; ch < NCH; ch++) check(nco_out[ch], 1'b0, "R6", "output right after disable");
      step(6);
      for (int ch = 0; ch < NCH; ch++) check(nco_out[ch], 1'b0, "R6", "output while disabled");
      enable_bank();
      run(40, "R6");
   endtask

   // R7: live tuning word change, no accumulator reset
   task automatic t_retune();
      wr(3, 0);
      setup(0, 'h60000, 0, 0, 0);
      setup(1, 0, 0, 0, 0);
      setup(2, 0, 0, 0, 0);
      enable_bank();
      step(2);
      check(nco_out[0], 1'b0, "R7", "tick1 acc=0x60000");
      wr(0, 'h10000);
      step(1);
      check(nco_out[0], 1'b0, "R7", "tick2 acc=0x70000 with new word");
      step(2);
      check(nco_out[0], 1'b1, "R7", "tick3 acc=0x80000 without reset");
      step(2);
      check(nco_out[0], 1'b1, "R7", "tick4 acc=0x90000");
   endtask

   // R8: write to the unused address has no effect
   task automatic t_unused_addr();
      wr(3, 0);
      setup(0, 'h40000, 0, 0, 0);
      setup(1, 'h20000, 1, 1, 1);
      setup(2, 'h80000, 2, 0, 0);
      enable_bank();
      run(10, "R8");
      wr(7, 'hFFFFF);
      cyc++;
      for (int ch = 0; ch < NCH; ch++)
         check(nco_out[ch], exp_out(ch, cyc), "R8", "after write to address 7");
      run(60, "R8");
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_fail++;
      $display("FAIL watchdog: got=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

   initial begin
      n_checks = 0;
      n_fail   = 0;
      cyc      = 0;
      rst_n    = 1'b0;
      wr_en    = 1'b0;
      wr_addr  = '0;
      wr_data  = '0;
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_square();
      t_pulse();
      t_slow_div();
      t_zero();
      t_disable();
      t_retune();
      t_unused_addr();
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

endmodule